// File: doc/BRIEF.md
# Dual Selectable Clock Divider

The block divides one input clock into two output clocks, each with its own 2-bit ratio select. Output A covers divide by 1, 2, 4 and 8. Output B covers the set shifted up by one power of two: divide by 2, 4, 8 and 16.

Both outputs are taken from taps of one shared down-counter, so their edges line up on the same input edge. An active-high `freeze` input, sampled on the falling input edge, stops the counter. While it is set, the divided outputs keep their level and the divide-by-1 path stays low, so no shortened pulse appears.

An asynchronous active-low `rst_n` clears everything. Several instances released from the same reset edge therefore run in step. A new ratio select is only applied at the counter wrap point.

Top module: `dual_clk_divider`

## Requirements
- R1: Output A ratio by `sel_a` code: 0 gives divide by 1, 1 gives divide by 2, 2 gives divide by 4, 3 gives divide by 8.
- R2: Output B ratio by `sel_b` code: 0 gives divide by 2, 1 gives divide by 4, 2 gives divide by 8, 3 gives divide by 16.
- R3: With `rst_n` high and `freeze` low, every rising `clk_in` edge advances the divider by one step.
- R4: All divided outputs rise on the same input edge each time the shared counter wraps, and on that edge the divide-by-1 output of A also rises.
- R5: With `freeze` high, both divided outputs keep their level and the divide-by-1 output of A stays low.
- R6: `freeze` is sampled on the falling `clk_in` edge and takes effect from the next rising edge, so every divide-by-1 high phase lasts a full input high phase.
- R7: `rst_n` low forces both outputs low at once, whatever the state of `clk_in` and `freeze`.
- R8: A change on `sel_a` or `sel_b` takes effect only on the rising edge where the counter leaves zero. Until then the old ratio continues.
- R9: After `rst_n` is released, the first advancing rising edge drives every divided output high. A divide-by-2^n output then stays high for 2^(n-1) advancing edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Clock to be divided |
| rst_n | input | 1 | Asynchronous master reset, active low |
| freeze | input | 1 | Hold request, active high, sampled on falling clock edge |
| sel_a | input | 2 | Ratio select for output A |
| sel_b | input | 2 | Ratio select for output B |
| out_a | output | 1 | Divided clock A (divide by 1, 2, 4 or 8) |
| out_b | output | 1 | Divided clock B (divide by 2, 4, 8 or 16) |

## Verification
The assertions take for granted that `freeze` and the select inputs never change right at a clock edge. They also assume `rst_n` is released while the clock is low, so that the falling-edge sample of `freeze` lands before the first rising edge that may advance the counter. The stimulus changes every input one time unit after a falling edge, and asserts or releases reset only in that window. Each output is sampled once inside the high phase and once inside the low phase of every input cycle.

// File: rtl/dclk_pkg.sv
package dclk_pkg;
  // log2 of the smallest ratio on each output
  localparam int A_BASE = 0;
  localparam int B_BASE = 1;

  // number of counter bits needed to serve the largest ratio on either output
  function automatic int taps_needed(int sel_w, int base_a, int base_b);
    int hi;
    hi = (base_a > base_b) ? base_a : base_b;
    return (1 << sel_w) - 1 + hi;
  endfunction
endpackage

// File: rtl/dclk_gate.sv
module dclk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic freeze,
  output logic run,
  output logic div1
);
  // falling-edge sample keeps the gated clock free of runt pulses
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) run <= 1'b0;
    else        run <= ~freeze;
  end

  assign div1 = clk & run;
endmodule

// File: rtl/dclk_counter.sv
module dclk_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [WIDTH-1:0] cnt,
  output logic             at_zero
);
  // down-counter: from zero, the first step sets every tap high together
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (adv) cnt <= cnt - WIDTH'(1);
  end

  assign at_zero = (cnt == '0);
endmodule

// File: rtl/dclk_select.sv
module dclk_select #(
  parameter int SEL_W  = 2,
  parameter int TAPS   = 4,
  parameter int OFFSET = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            at_zero,
  input  logic [SEL_W-1:0] sel,
  input  logic            div1,
  input  logic [TAPS-1:0] taps,
  output logic            clk_out
);
  localparam int NSRC  = TAPS + 1;
  localparam int IDX_W = $clog2(NSRC);

  logic [SEL_W-1:0] sel_q;
  logic [NSRC-1:0]  src;
  logic [IDX_W-1:0] idx;

  // ratio is swapped only where all taps are low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sel_q <= '0;
    else if (adv && at_zero) sel_q <= sel;
  end

  assign src[0] = div1;
  generate
    for (genvar i = 1; i < NSRC; i++) begin : g_src
      assign src[i] = taps[i-1];
    end
  endgenerate

  assign idx     = IDX_W'(sel_q) + IDX_W'(OFFSET);
  assign clk_out = src[idx];

  // R8
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(adv && at_zero) |=> $stable(sel_q));
endmodule

// File: rtl/dual_clk_divider.sv
module dual_clk_divider #(
  parameter int SEL_W = 2
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic [SEL_W-1:0] sel_a,
  input  logic [SEL_W-1:0] sel_b,
  output logic             out_a,
  output logic             out_b
);
  import dclk_pkg::*;

  localparam int CNT_W = taps_needed(SEL_W, A_BASE, B_BASE);

  logic             run;
  logic             div1;
  logic [CNT_W-1:0] cnt;
  logic             at_zero;

  dclk_gate u_gate (
    .clk(clk_in), .rst_n(rst_n), .freeze(freeze), .run(run), .div1(div1)
  );

  dclk_counter #(.WIDTH(CNT_W)) u_cnt (
    .clk(clk_in), .rst_n(rst_n), .adv(run), .cnt(cnt), .at_zero(at_zero)
  );

  dclk_select #(.SEL_W(SEL_W), .TAPS(CNT_W), .OFFSET(A_BASE)) u_sel_a (
    .clk(clk_in), .rst_n(rst_n), .adv(run), .at_zero(at_zero),
    .sel(sel_a), .div1(div1), .taps(cnt), .clk_out(out_a)
  );

  dclk_select #(.SEL_W(SEL_W), .TAPS(CNT_W), .OFFSET(B_BASE)) u_sel_b (
    .clk(clk_in), .rst_n(rst_n), .adv(run), .at_zero(at_zero),
    .sel(sel_b), .div1(div1), .taps(cnt), .clk_out(out_b)
  );

  // R5
  hold_level_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    !run |=> $stable(out_b));

  // R4
  wrap_align_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (run && at_zero) |=> (out_b && cnt == '1));

  // R5 / R6
  div1_quiet_chk: assert property (@(negedge clk_in) disable iff (!rst_n)
    (!run && sel_a == '0 && $stable(sel_a)) |-> !out_a);

  // R3
  advance_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (run && !at_zero) |=> (cnt != '1));
endmodule

// File: tb/dual_clk_divider_test.sv
module dual_clk_divider_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       freeze = 1'b0;
  logic [1:0] sel_a = 2'd0;
  logic [1:0] sel_b = 2'd0;
  logic       out_a, out_b;

  int n_chk = 0;
  int n_bad = 0;

  // bench model state
  int k = 0;
  int eff_a = 0;
  int eff_b = 0;
  bit run_m = 0;
  string tag_a = "R1";
  string tag_b = "R2";

  always #2 clk = ~clk;

  dual_clk_divider uut (
    .clk_in(clk), .rst_n(rst_n), .freeze(freeze),
    .sel_a(sel_a), .sel_b(sel_b), .out_a(out_a), .out_b(out_b)
  );

  task automatic check(string tag, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit tap(int b);
    int c;
    c = (16 - (k % 16)) % 16;
    return bit'((c >> b) & 1);
  endfunction

  // one input cycle: model the rising edge, check high phase, then low phase
  task automatic cycle();
    @(posedge clk);
    if (rst_n && run_m) begin
      if (k % 16 == 0) begin
        eff_a = int'(sel_a);
        eff_b = int'(sel_b);
      end
      k++;
    end
    #1;
    check(tag_a, out_a, (eff_a == 0) ? logic'(run_m) : logic'(tap(eff_a - 1)));
    check(tag_b, out_b, logic'(tap(eff_b)));
    @(negedge clk);
    run_m = rst_n && !freeze;
    #1;
    check(tag_a, out_a, (eff_a == 0) ? 1'b0 : logic'(tap(eff_a - 1)));
    check(tag_b, out_b, logic'(tap(eff_b)));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    k = 0; eff_a = 0; eff_b = 0; run_m = 0;
    #0.5;
    check("R7", out_a, 1'b0);
    check("R7", out_b, 1'b0);
    cycle();
    cycle();
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); #1;
    tag_a = "R7"; tag_b = "R7";
    check("R7", out_a, 1'b0);
    check("R7", out_b, 1'b0);

    // R1 R2 R3: sweep every select pair from a fresh reset
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        sel_a = 2'(a); sel_b = 2'(b);
        do_reset();
        tag_a = "R1"; tag_b = "R2";
        cycle();            // run sampled on the falling edge
        cycle();            // first advancing edge
        check("R9", out_b, 1'b1);
        if (a != 0) check("R9", out_a, 1'b1);
        for (int i = 0; i < 34; i++) cycle();
      end
    end

    // R4: at each wrap A on divide by 1 and B on divide by 16 rise together
    sel_a = 2'd0; sel_b = 2'd3;
    do_reset();
    tag_a = "R4"; tag_b = "R4";
    for (int i = 0; i < 40; i++) begin
      cycle();
      if (k % 16 == 1) begin
        check("R4", out_b, 1'b1);
        check("R3", logic'(k > 0), 1'b1);
      end
    end

    // R5 R6: freeze pulses of different lengths on different ratios
    sel_a = 2'd0; sel_b = 2'd1;
    do_reset();
    tag_a = "R5"; tag_b = "R5";
    for (int i = 0; i < 60; i++) begin
      freeze = ((i % 7) == 3) || ((i % 11) >= 5 && (i % 11) < 8);
      tag_a = freeze ? "R5" : "R6";
      cycle();
    end
    freeze = 1'b0;
    sel_a = 2'd2; sel_b = 2'd2;
    for (int i = 0; i < 40; i++) begin
      freeze = (i % 5) == 2;
      cycle();
    end
    freeze = 1'b0;

    // R8: ratio changes mid-count apply only at the wrap
    sel_a = 2'd1; sel_b = 2'd0;
    do_reset();
    tag_a = "R8"; tag_b = "R8";
    for (int i = 0; i < 100; i++) begin
      if (i % 13 == 6) begin
        sel_a = 2'(i % 4);
        sel_b = 2'((i / 3) % 4);
      end
      cycle();
    end

    // R7: reset in the middle of a count with freeze active
    freeze = 1'b1;
    do_reset();
    freeze = 1'b0;
    tag_a = "R9"; tag_b = "R9";
    for (int i = 0; i < 10; i++) cycle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule